// File: doc/BRIEF.md
# Scaled Eight-Point Forward DCT Pipeline

This block computes a one-dimensional, eight-point forward discrete cosine transform in scaled form. It takes a serial stream of signed samples, eight per vector, and returns a serial stream of eight coefficients per vector, each tagged with its frequency index. The fixed per-coefficient gain that the factorisation leaves on each output is not removed here. A later quantisation stage is expected to absorb it into its divisors.

The transform is factorised into six steps: mirrored butterflies, two rounds of sums and differences, one round of constant multiplications, and two more rounds of sums and differences. Across all six steps there are 29 additions or subtractions and 5 constant multiplications. Each step owns one arithmetic operator, which it reuses over eight clock cycles per vector. Double-buffered vector storage between the steps lets a step fill one bank while the next step reads the other. The input side collects a vector in the same double-buffered way. Because of this, a new vector can enter every eight cycles, and coefficients leave in a gap-free stream.

Internally, samples are widened with fractional guard bits. Each constant product is rounded back to that precision. Each output is rounded to an integer once, at the very end.

Top module: `dct8_scaled`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` stays low until a complete eight-sample vector has been taken.
- R2: A sample is taken only on a rising edge where `in_valid` is high. The first sample taken is x0 and the eighth is x7. Idle cycles in the middle of a vector keep the samples already taken and produce no output.
- R3: Coefficient k of a vector is presented in the cycle after the (41+k)-th rising edge that follows the edge taking its eighth sample. With samples on consecutive cycles, coefficient 0 appears 48 cycles after the first sample.
- R4: Each vector yields `out_valid` high for eight consecutive cycles, with `out_index` running 0, 1, …, 7 in order.
- R5: With F_k = Σn x_n·cos((2n+1)kπ/16), coefficient k equals F_k·g_k, where g_0 = 1 and g_k = 2·cos(kπ/16) for k ≥ 1. The result is within 1 LSB of that real value.
- R6: Vectors whose samples arrive back to back are all transformed without loss, one vector every eight cycles, and their outputs follow each other with no idle cycle.
- R7: Full-scale inputs, including alternating maximum positive and maximum negative samples, produce no internal overflow and stay within the R5 tolerance.
- R8: Samples are IN_W-bit two's complement and coefficients are (IN_W+5)-bit two's complement. Coefficients 0 and 4 involve no multiplication and are exactly Σ x_n and x0−x1−x2+x3+x4−x5−x6+x7.
- R9: A vector of eight equal samples gives coefficients 1 to 7 exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | Coefficient qualifier |
| out_coef | output | IN_W+5 | Signed scaled coefficient |
| out_index | output | 3 | Frequency index of `out_coef` |

## Verification
Several properties are checked on every clock. The output index must start at zero and rise by one each valid cycle. No step may be restarted while it is still processing. The write pointer of a partly collected vector must hold while input is idle. No addition or subtraction may wrap its operand width. Only the bench scenarios can show the coefficient values against a real-valued transform, the exact zeros for constant vectors, the exact DC and index-4 results, and the 41+k cycle timing under back-to-back, gapped and partial input.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  // entries per intermediate vector (step 3 yields nine)
  localparam int NE = 9;

  typedef enum logic [1:0] {OP_PASS, OP_ADD, OP_SUB, OP_MUL} op_e;

  // one time slot of a step: operator lane plus a plain copy lane
  typedef struct packed {
    op_e        op;
    logic [3:0] a;
    logic [3:0] b;       // second operand, or constant select for OP_MUL
    logic [3:0] dst;     // 15 = no write
    logic       cp_en;
    logic [3:0] cp_src;
    logic [3:0] cp_dst;
  } slot_t;

  function automatic slot_t mk(op_e op, logic [3:0] a, logic [3:0] b, logic [3:0] dst,
                               logic ce, logic [3:0] cs, logic [3:0] cd);
    slot_t s;
    s.op = op; s.a = a; s.b = b; s.dst = dst;
    s.cp_en = ce; s.cp_src = cs; s.cp_dst = cd;
    return s;
  endfunction

  // operation schedule of each step, one slot per cycle
  function automatic slot_t schedule(int step, logic [2:0] slot);
    slot_t s;
    s = mk(OP_PASS, 4'd0, 4'd0, 4'd15, 1'b0, 4'd0, 4'd0);
    case (step)
      1: case (slot)
        3'd0: s = mk(OP_ADD, 4'd0, 4'd7, 4'd0, 1'b0, 4'd0, 4'd0);
        3'd1: s = mk(OP_ADD, 4'd1, 4'd6, 4'd1, 1'b0, 4'd0, 4'd0);
        3'd2: s = mk(OP_SUB, 4'd3, 4'd4, 4'd2, 1'b0, 4'd0, 4'd0);
        3'd3: s = mk(OP_SUB, 4'd1, 4'd6, 4'd3, 1'b0, 4'd0, 4'd0);
        3'd4: s = mk(OP_ADD, 4'd2, 4'd5, 4'd4, 1'b0, 4'd0, 4'd0);
        3'd5: s = mk(OP_ADD, 4'd3, 4'd4, 4'd5, 1'b0, 4'd0, 4'd0);
        3'd6: s = mk(OP_SUB, 4'd2, 4'd5, 4'd6, 1'b0, 4'd0, 4'd0);
        default: s = mk(OP_SUB, 4'd0, 4'd7, 4'd7, 1'b0, 4'd0, 4'd0);
      endcase
      2: case (slot)
        3'd0: s = mk(OP_ADD, 4'd0, 4'd5, 4'd0, 1'b1, 4'd7, 4'd7);
        3'd1: s = mk(OP_SUB, 4'd1, 4'd4, 4'd1, 1'b0, 4'd0, 4'd0);
        3'd2: s = mk(OP_ADD, 4'd2, 4'd6, 4'd2, 1'b0, 4'd0, 4'd0);
        3'd3: s = mk(OP_ADD, 4'd1, 4'd4, 4'd3, 1'b0, 4'd0, 4'd0);
        3'd4: s = mk(OP_SUB, 4'd0, 4'd5, 4'd4, 1'b0, 4'd0, 4'd0);
        3'd5: s = mk(OP_ADD, 4'd3, 4'd7, 4'd5, 1'b0, 4'd0, 4'd0);
        3'd6: s = mk(OP_ADD, 4'd3, 4'd6, 4'd6, 1'b0, 4'd0, 4'd0);
        default: ;
      endcase
      3: case (slot)
        3'd0: s = mk(OP_ADD, 4'd0, 4'd3, 4'd0, 1'b1, 4'd2, 4'd2);
        3'd1: s = mk(OP_SUB, 4'd0, 4'd3, 4'd1, 1'b1, 4'd4, 4'd5);
        3'd2: s = mk(OP_ADD, 4'd1, 4'd4, 4'd3, 1'b1, 4'd5, 4'd6);
        3'd3: s = mk(OP_SUB, 4'd2, 4'd5, 4'd4, 1'b1, 4'd6, 4'd7);
        3'd4: s = mk(OP_PASS, 4'd0, 4'd0, 4'd15, 1'b1, 4'd7, 4'd8);
        default: ;
      endcase
      4: case (slot)  // b selects constant: 0 cos(4pi/16), 1 cos(6pi/16), 2 difference, 3 sum
        3'd0: s = mk(OP_MUL, 4'd2, 4'd2, 4'd2, 1'b1, 4'd0, 4'd0);
        3'd1: s = mk(OP_MUL, 4'd7, 4'd0, 4'd3, 1'b1, 4'd1, 4'd1);
        3'd2: s = mk(OP_MUL, 4'd6, 4'd3, 4'd4, 1'b1, 4'd5, 4'd5);
        3'd3: s = mk(OP_MUL, 4'd3, 4'd0, 4'd6, 1'b1, 4'd8, 4'd8);
        3'd4: s = mk(OP_MUL, 4'd4, 4'd1, 4'd7, 1'b0, 4'd0, 4'd0);
        default: ;
      endcase
      5: case (slot)
        3'd0: s = mk(OP_ADD, 4'd5, 4'd6, 4'd2, 1'b1, 4'd0, 4'd0);
        3'd1: s = mk(OP_SUB, 4'd5, 4'd6, 4'd3, 1'b1, 4'd1, 4'd1);
        3'd2: s = mk(OP_ADD, 4'd3, 4'd8, 4'd4, 1'b0, 4'd0, 4'd0);
        3'd3: s = mk(OP_SUB, 4'd8, 4'd3, 4'd5, 1'b0, 4'd0, 4'd0);
        3'd4: s = mk(OP_ADD, 4'd2, 4'd7, 4'd6, 1'b0, 4'd0, 4'd0);
        3'd5: s = mk(OP_ADD, 4'd4, 4'd7, 4'd7, 1'b0, 4'd0, 4'd0);
        default: ;
      endcase
      default: case (slot)  // step 6: slot k yields coefficient k
        3'd0: s = mk(OP_PASS, 4'd0, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0);
        3'd1: s = mk(OP_ADD, 4'd4, 4'd7, 4'd1, 1'b0, 4'd0, 4'd0);
        3'd2: s = mk(OP_PASS, 4'd2, 4'd0, 4'd2, 1'b0, 4'd0, 4'd0);
        3'd3: s = mk(OP_SUB, 4'd5, 4'd6, 4'd3, 1'b0, 4'd0, 4'd0);
        3'd4: s = mk(OP_PASS, 4'd1, 4'd0, 4'd4, 1'b0, 4'd0, 4'd0);
        3'd5: s = mk(OP_ADD, 4'd5, 4'd6, 4'd5, 1'b0, 4'd0, 4'd0);
        3'd6: s = mk(OP_PASS, 4'd3, 4'd0, 4'd6, 1'b0, 4'd0, 4'd0);
        default: s = mk(OP_SUB, 4'd4, 4'd7, 4'd7, 1'b0, 4'd0, 4'd0);
      endcase
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dct8_gather.sv
module dct8_gather #(
  parameter int IN_W = 8,
  parameter int W    = 17,
  parameter int G    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic signed [IN_W-1:0]          in_sample,
  output logic                            vec_done,
  output logic [dct8_pkg::NE*W-1:0]       vec
);
  localparam int NE = dct8_pkg::NE;

  logic signed [W-1:0] bank [2][8];
  logic [2:0] wptr;
  logic       wsel;

  assign vec_done = in_valid && (wptr == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      wsel <= 1'b0;
    end else if (in_valid) begin
      wptr <= wptr + 3'd1;
      if (wptr == 3'd7) wsel <= ~wsel;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid)
      bank[wsel][wptr] <= {{(W-IN_W-G){in_sample[IN_W-1]}}, in_sample, {G{1'b0}}};
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < 8; i++) vec[i*W +: W] = bank[~wsel][i];
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wptr) && $stable(wsel));

endmodule

// File: rtl/dct8_step.sv
module dct8_step
  import dct8_pkg::*;
#(
  parameter int STEP = 1,
  parameter int W    = 17,
  parameter int CF   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NE*W-1:0]        src_vec,
  output logic                   run_o,
  output logic [2:0]             slot_o,
  output logic signed [W-1:0]    res_o,
  output logic                   done_o,
  output logic [NE*W-1:0]        rd_vec
);
  localparam int AW = W + CF + 2;
  localparam logic [CF:0] K_C4  = (CF+1)'($rtoi(0.7071067811865476 * (2.0 ** CF) + 0.5));
  localparam logic [CF:0] K_C6  = (CF+1)'($rtoi(0.3826834323650898 * (2.0 ** CF) + 0.5));
  localparam logic [CF:0] K_DIF = (CF+1)'($rtoi(0.5411961001461970 * (2.0 ** CF) + 0.5));
  localparam logic [CF:0] K_SUM = (CF+1)'($rtoi(1.3065629648763766 * (2.0 ** CF) + 0.5));

  // constant product as a sum of shifted copies, rounded back to W bits
  function automatic logic signed [W-1:0] cmul(logic signed [W-1:0] x, logic [CF:0] k);
    logic signed [AW-1:0] acc;
    acc = '0;
    for (int i = 0; i <= CF; i++)
      if (k[i]) acc = acc + (AW'(x) <<< i);
    return W'((acc + AW'(1 <<< (CF-1))) >>> CF);
  endfunction

  function automatic logic [CF:0] kpick(logic [1:0] ks);
    case (ks)
      2'd0:    return K_C4;
      2'd1:    return K_C6;
      2'd2:    return K_DIF;
      default: return K_SUM;
    endcase
  endfunction

  function automatic logic signed [W-1:0] alu(op_e op, logic signed [W-1:0] x,
                                              logic signed [W-1:0] y, logic [1:0] ks);
    case (op)
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_MUL:  return cmul(x, kpick(ks));
      default: return x;
    endcase
  endfunction

  logic                run;
  logic [2:0]          slot;
  logic                wsel;
  logic signed [W-1:0] bank [2][NE];
  logic signed [W-1:0] src  [NE];
  logic signed [W-1:0] opa, opb, res;
  slot_t               d;

  always_comb begin
    for (int i = 0; i < NE; i++) src[i] = src_vec[i*W +: W];
  end

  assign d      = schedule(STEP, slot);
  assign opa    = src[d.a];
  assign opb    = src[d.b];
  assign res    = alu(d.op, opa, opb, d.b[1:0]);
  assign done_o = run && (slot == 3'd7);
  assign run_o  = run;
  assign slot_o = slot;
  assign res_o  = res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      slot <= '0;
      wsel <= 1'b0;
    end else begin
      if (start) begin
        run  <= 1'b1;
        slot <= '0;
      end else if (run) begin
        if (slot == 3'd7) run <= 1'b0;
        slot <= slot + 3'd1;
      end
      if (done_o) wsel <= ~wsel;
    end
  end

  always_ff @(posedge clk) begin
    if (run) begin
      bank[wsel][d.dst] <= res;
      if (d.cp_en) bank[wsel][d.cp_dst] <= src[d.cp_src];
    end
  end

  always_comb begin
    for (int i = 0; i < NE; i++) rd_vec[i*W +: W] = bank[~wsel][i];
  end

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!run || slot == 3'd7));

  // R7
  no_add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && d.op == OP_ADD && opa[W-1] == opb[W-1] |-> res[W-1] == opa[W-1]);

  // R7
  no_sub_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && d.op == OP_SUB && opa[W-1] != opb[W-1] |-> res[W-1] == opa[W-1]);

endmodule

// File: rtl/dct8_scaled.sv
module dct8_scaled #(
  parameter  int IN_W       = 8,
  parameter  int GUARD      = 4,
  parameter  int CONST_FRAC = 12,
  localparam int OUT_W      = IN_W + 5,
  localparam int W          = OUT_W + GUARD
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_sample,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_coef,
  output logic [2:0]               out_index
);
  localparam int VW    = dct8_pkg::NE * W;
  localparam int NSTEP = 6;

  function automatic logic signed [OUT_W-1:0] to_coef(logic signed [W-1:0] v);
    return OUT_W'((v + W'(1 <<< (GUARD-1))) >>> GUARD);
  endfunction

  logic [VW-1:0]       vec_w  [0:NSTEP];
  logic                done_w [0:NSTEP];
  logic                run_w  [1:NSTEP];
  logic [2:0]          slot_w [1:NSTEP];
  logic signed [W-1:0] res_w  [1:NSTEP];
  logic                vec_done;

  dct8_gather #(.IN_W(IN_W), .W(W), .G(GUARD)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .vec_done (vec_done),
    .vec      (vec_w[0])
  );
  assign done_w[0] = vec_done;

  for (genvar k = 1; k <= NSTEP; k++) begin : g_step
    dct8_step #(.STEP(k), .W(W), .CF(CONST_FRAC)) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (done_w[k-1]),
      .src_vec(vec_w[k-1]),
      .run_o  (run_w[k]),
      .slot_o (slot_w[k]),
      .res_o  (res_w[k]),
      .done_o (done_w[k]),
      .rd_vec (vec_w[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_coef  <= '0;
      out_index <= '0;
    end else begin
      out_valid <= run_w[NSTEP];
      out_index <= slot_w[NSTEP];
      out_coef  <= to_coef(res_w[NSTEP]);
    end
  end

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_index != 3'd7 |=> out_valid && out_index == $past(out_index) + 3'd1);

  // R4
  idx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_index == 3'd0);

endmodule

// File: tb/dct8_scaled_test.sv
module dct8_scaled_test;
  localparam int IN_W  = 8;
  localparam int OUT_W = IN_W + 5;
  localparam real PI   = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0]  in_sample = '0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_coef;
  logic [2:0]              out_index;

  always #4 clk = ~clk;  // 125 MHz

  dct8_scaled uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_coef(out_coef), .out_index(out_index)
  );

  typedef struct {
    int    due;
    int    idx;
    real   val;
    real   tol;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  int    smp[8];
  int    nfill = 0;
  string cur_tag = "R5";
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input real act, input real expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0f expected=%0f (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic real ref_coef(int k);
    real f;
    f = 0.0;
    for (int n = 0; n < 8; n++) f += smp[n] * $cos((2*n + 1) * k * PI / 16.0);
    if (k != 0) f = f * 2.0 * $cos(k * PI / 16.0);
    return f;
  endfunction

  // behavioural reference: collects samples, schedules expected outputs
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && in_valid) begin
      smp[nfill] = int'(in_sample);
      nfill++;
      if (nfill == 8) begin
        bit flat;
        flat = 1'b1;
        for (int n = 1; n < 8; n++) if (smp[n] != smp[0]) flat = 1'b0;
        for (int k = 0; k < 8; k++) begin
          exp_t e;
          e.due = cyc + 41 + k;
          e.idx = k;
          e.val = ref_coef(k);
          if (k == 0 || k == 4) begin e.tol = 0.01; e.tag = "R8"; end
          else if (flat)        begin e.tol = 0.01; e.tag = "R9"; end
          else                  begin e.tol = 1.0;  e.tag = cur_tag; end
          q.push_back(e);
        end
        nfill = 0;
      end
    end
  end

  // compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk(out_valid == 1'b0, "R1", "out_valid in reset", real'(out_valid), 0.0);
      end else begin
        bit ev;
        ev = (q.size() > 0) && (q[0].due == cyc);
        chk(out_valid == ev, "R3", "out_valid timing", real'(out_valid), real'(ev));
        if (ev) begin
          exp_t e;
          real diff;
          e = q.pop_front();
          if (out_valid) begin
            chk(int'(out_index) == e.idx, "R4", "out_index", real'(out_index), real'(e.idx));
            diff = real'(out_coef) - e.val;
            if (diff < 0.0) diff = -diff;
            chk(diff <= e.tol, e.tag, $sformatf("coef %0d", e.idx), real'(out_coef), e.val);
          end
        end
      end
    end
  end

  task automatic put(input int v);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = IN_W'(v);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send(input int s[8], input string tag, input bit gaps);
    cur_tag = tag;
    for (int i = 0; i < 8; i++) begin
      if (gaps) idle(int'($urandom_range(0, 2)));
      put(s[i]);
    end
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int v[8];
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R9 / R8: constant vectors, back to back
    for (int i = 0; i < 8; i++) v[i] = 0;
    send(v, "R9", 1'b0);
    for (int i = 0; i < 8; i++) v[i] = 127;
    send(v, "R9", 1'b0);
    for (int i = 0; i < 8; i++) v[i] = -128;
    send(v, "R8", 1'b0);

    // R7: full-scale alternation, both phases
    for (int i = 0; i < 8; i++) v[i] = (i % 2 == 0) ? 127 : -128;
    send(v, "R7", 1'b0);
    for (int i = 0; i < 8; i++) v[i] = (i % 2 == 0) ? -128 : 127;
    send(v, "R7", 1'b0);
    for (int i = 0; i < 8; i++) v[i] = (i < 4) ? 127 : -128;
    send(v, "R7", 1'b0);

    // R5: impulse and ramp
    for (int i = 0; i < 8; i++) v[i] = (i == 3) ? 100 : 0;
    send(v, "R5", 1'b0);
    for (int i = 0; i < 8; i++) v[i] = i * 30 - 110;
    send(v, "R5", 1'b0);

    // R6: random vectors back to back
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 8; i++) v[i] = int'($urandom_range(0, 255)) - 128;
      send(v, "R6", 1'b0);
    end
    idle(60);

    // R2: random vectors with idle cycles inside
    for (int n = 0; n < 10; n++) begin
      for (int i = 0; i < 8; i++) v[i] = int'($urandom_range(0, 255)) - 128;
      send(v, "R2", 1'b1);
    end

    // R2: partial vector held over a long idle stretch
    cur_tag = "R2";
    put(-7); put(55); put(-128); put(3); put(90);
    idle(70);
    put(-33); put(127); put(12);
    idle(80);

    chk(q.size() == 0, "R3", "outstanding outputs", real'(q.size()), 0.0);
    summary();
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

endmodule